// File: doc/BRIEF.md
# Low-Power ADC Sampling Sequencer

This block drives an external multi-channel analog-to-digital converter from an always-on clock. When enabled it lifts the converter out of power-down and waits a configured settling count. It then selects each channel in ascending order and holds each select until the converter returns that channel's result over a valid strobe. Every result is compared against an inclusive per-channel window. A burst matches when every channel in it falls inside its window.

Two sampling modes exist. In normal-power mode bursts repeat back to back with the converter left powered. Consecutive matching bursts are counted, and the interrupt output is raised once the count reaches a threshold. In low-power mode the converter is powered down after each burst, and bursts start on a fixed wakeup period. Matching bursts advance a separate low-power counter. When that counter reaches its own threshold, the sequencer changes to continuous sampling, and the wakeup output then follows the interrupt. The state machine and all four counters clear on the asynchronous reset, on a synchronous software reset bit, and when the enable input drops.

Top module: `adc_lp_sampler`

## Requirements
- R1: While rst_ni is low, and from the moment it falls without waiting for a clock edge, adc_pd_o is 1, adc_chn_sel_o is all zero, and intr_o and wakeup_o are 0.
- R2: While fsm_rst_i is high, the sequencer returns to idle on the next edge with all counters cleared and adc_pd_o high. After fsm_rst_i is released it runs a full power-up wait again, and the match count restarts from zero.
- R3: At most one bit of adc_chn_sel_o is high in any cycle, and no bit is ever unknown after reset.
- R4: adc_pd_o is low for exactly pwrup_time_i cycles (pwrup_time_i of 1 or more) before channel 0 is selected.
- R5: In low-power mode, adc_pd_o stays high from the end of a burst until the next burst starts.
- R6: In low-power mode, consecutive burst starts (falling edges of adc_pd_o) are exactly wakeup_time_i cycles apart, provided that period is longer than a burst.
- R7: Channels are selected one at a time, 0 first. A select stays high until a cycle with adc_valid_i high, and the result is taken from adc_data_i in that cycle.
- R8: A channel i result matches when lo <= data <= hi, with both bounds included. lo and hi are taken from bits [i*DATA_W +: DATA_W] of flt_lo_i and flt_hi_i. A burst matches only when every channel in it matches.
- R9: The mode can change in either direction at any time. With lp_mode_i high, the next burst ends in power-down. Dropping lp_mode_i while powered down starts a power-up on the next cycle.
- R10: In low-power mode a matching burst increments the low-power count and a non-matching burst clears it. When a match brings the count to lp_thresh_i, sampling continues back to back without power-down, and the normal-power count restarts from zero.
- R11: In normal-power sampling a matching burst increments the normal-power count (saturating) and a non-matching burst clears it. intr_o is high while np_thresh_i is nonzero and the count is at least np_thresh_i. wakeup_o equals intr_o while the low-power promotion is in effect with lp_mode_i still high, and is 0 otherwise.
- R12: When en_i is low the sequencer is idle on the next edge: adc_pd_o high, no channel selected, and all counters cleared, so intr_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Sequencer enable |
| fsm_rst_i | input | 1 | Synchronous software reset of state and counters |
| lp_mode_i | input | 1 | 1 selects low-power mode, 0 selects normal-power mode |
| pwrup_time_i | input | PWR_W | Settling cycles between power-up and first select |
| wakeup_time_i | input | WAKE_W | Low-power burst period in cycles |
| lp_thresh_i | input | CNT_W | Matching bursts needed to leave low-power mode |
| np_thresh_i | input | CNT_W | Matching bursts needed to raise intr_o (0 disables) |
| flt_lo_i | input | NUM_CH*DATA_W | Per-channel lower window bounds |
| flt_hi_i | input | NUM_CH*DATA_W | Per-channel upper window bounds |
| adc_data_i | input | DATA_W | Conversion result |
| adc_valid_i | input | 1 | Result valid for the selected channel |
| adc_pd_o | output | 1 | Converter power-down |
| adc_chn_sel_o | output | NUM_CH | One-hot channel select |
| intr_o | output | 1 | Match-count interrupt |
| wakeup_o | output | 1 | Wakeup request after low-power promotion |

## Verification
The hardest situation to reach is the promotion from low-power to continuous sampling. A count of lp_thresh_i matching bursts has to build up across separate power-down periods, with a miss in between that must restart the count. The stimulus drives bursts in low-power mode with a wakeup period long enough to measure the power-down gap and the burst-to-burst interval. It gives a match, then a miss, then three matches, and checks that adc_pd_o stays low after the last one. It then keeps sampling in normal-power fashion until intr_o and wakeup_o both rise.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PWRUP,
    ST_SAMPLE,
    ST_EVAL,
    ST_SLEEP
  } seq_state_e;
endpackage

// File: rtl/adc_seq_counter.sv
module adc_seq_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         run_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = '1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (clr_i)                   cnt_q <= '0;
    else if (run_i && cnt_q != MAX)   cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;

  // R2
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == '0);

  // R11
  step_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && run_i && cnt_o != MAX) |=> cnt_o == $past(cnt_o) + W'(1));
endmodule

// File: rtl/adc_seq_filter.sv
module adc_seq_filter #(
  parameter int unsigned DATA_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] lo_i,
  input  logic [DATA_W-1:0] hi_i,
  output logic              hit_o
);
  logic in_win;
  logic hit_q;

  assign in_win = (data_i >= lo_i) && (data_i <= hi_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hit_q <= 1'b0;
    else if (clr_i)  hit_q <= 1'b0;
    else if (cap_i)  hit_q <= in_win;
  end

  assign hit_o = hit_q;

  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !cap_i) |=> $stable(hit_o));
endmodule

// File: rtl/adc_lp_sampler.sv
module adc_lp_sampler
  import adc_seq_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned DATA_W = 10,
  parameter int unsigned PWR_W  = 8,
  parameter int unsigned WAKE_W = 16,
  parameter int unsigned CNT_W  = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic                     fsm_rst_i,
  input  logic                     lp_mode_i,
  input  logic [PWR_W-1:0]         pwrup_time_i,
  input  logic [WAKE_W-1:0]        wakeup_time_i,
  input  logic [CNT_W-1:0]         lp_thresh_i,
  input  logic [CNT_W-1:0]         np_thresh_i,
  input  logic [NUM_CH*DATA_W-1:0] flt_lo_i,
  input  logic [NUM_CH*DATA_W-1:0] flt_hi_i,
  input  logic [DATA_W-1:0]        adc_data_i,
  input  logic                     adc_valid_i,
  output logic                     adc_pd_o,
  output logic [NUM_CH-1:0]        adc_chn_sel_o,
  output logic                     intr_o,
  output logic                     wakeup_o
);
  localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  seq_state_e state_q, state_d;
  logic [CH_W-1:0] ch_q, ch_d;
  logic promoted_q;

  logic [PWR_W-1:0]  pwr_cnt;
  logic [WAKE_W-1:0] wk_cnt;
  logic [CNT_W-1:0]  lp_cnt, np_cnt;
  logic [NUM_CH-1:0] ch_hit;

  logic sync_clr, lp_eff, burst_hit, eval_q;
  logic pwr_done, wk_done, lp_reach, promote;
  logic lp_clr, lp_inc, np_clr, np_inc, pwr_clr, wk_clr;
  logic np_hit;

  assign sync_clr  = fsm_rst_i | ~en_i;
  assign lp_eff    = lp_mode_i & ~promoted_q;
  assign burst_hit = &ch_hit;
  assign eval_q    = (state_q == ST_EVAL);

  assign pwr_done = ({1'b0, pwr_cnt} + (PWR_W+1)'(1))  >= {1'b0, pwrup_time_i};
  assign wk_done  = ({1'b0, wk_cnt}  + (WAKE_W+1)'(1)) >= {1'b0, wakeup_time_i};
  assign lp_reach = ({1'b0, lp_cnt}  + (CNT_W+1)'(1))  >= {1'b0, lp_thresh_i};
  assign promote  = eval_q && lp_eff && burst_hit && lp_reach && !sync_clr;

  always_comb begin
    state_d = state_q;
    ch_d    = ch_q;
    unique case (state_q)
      ST_IDLE:  state_d = ST_PWRUP;
      ST_PWRUP: if (pwr_done) begin
        state_d = ST_SAMPLE;
        ch_d    = '0;
      end
      ST_SAMPLE: if (adc_valid_i) begin
        if (ch_q == LAST_CH) state_d = ST_EVAL;
        else                 ch_d    = ch_q + CH_W'(1);
      end
      ST_EVAL: begin
        ch_d = '0;
        if (lp_eff && !promote) state_d = ST_SLEEP;
        else                    state_d = ST_SAMPLE;
      end
      ST_SLEEP: if (!lp_mode_i || wk_done) state_d = ST_PWRUP;
      default:  state_d = ST_IDLE;
    endcase
    if (sync_clr) begin
      state_d = ST_IDLE;
      ch_d    = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      ch_q       <= '0;
      promoted_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ch_q    <= ch_d;
      if (sync_clr || !lp_mode_i) promoted_q <= 1'b0;
      else if (promote)           promoted_q <= 1'b1;
    end
  end

  // counters and timers
  assign pwr_clr = sync_clr | (state_q != ST_PWRUP);
  assign wk_clr  = sync_clr | ((state_d == ST_PWRUP) && (state_q != ST_PWRUP));
  assign lp_inc  = eval_q && lp_eff && burst_hit;
  assign lp_clr  = sync_clr | (eval_q && lp_eff && !burst_hit) | promote;
  assign np_inc  = eval_q && !lp_eff && burst_hit;
  assign np_clr  = sync_clr | (eval_q && !lp_eff && !burst_hit) | promote;

  adc_seq_counter #(.W(PWR_W)) u_pwr_tmr (
    .clk_i, .rst_ni, .clr_i(pwr_clr), .run_i(1'b1), .cnt_o(pwr_cnt));
  adc_seq_counter #(.W(WAKE_W)) u_wk_tmr (
    .clk_i, .rst_ni, .clr_i(wk_clr), .run_i(1'b1), .cnt_o(wk_cnt));
  adc_seq_counter #(.W(CNT_W)) u_lp_cnt (
    .clk_i, .rst_ni, .clr_i(lp_clr), .run_i(lp_inc), .cnt_o(lp_cnt));
  adc_seq_counter #(.W(CNT_W)) u_np_cnt (
    .clk_i, .rst_ni, .clr_i(np_clr), .run_i(np_inc), .cnt_o(np_cnt));

  // per-channel window filters and selects
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic cap;
    assign cap = (state_q == ST_SAMPLE) && adc_valid_i && (ch_q == CH_W'(i));

    adc_seq_filter #(.DATA_W(DATA_W)) u_flt (
      .clk_i,
      .rst_ni,
      .clr_i (sync_clr),
      .cap_i (cap),
      .data_i(adc_data_i),
      .lo_i  (flt_lo_i[i*DATA_W +: DATA_W]),
      .hi_i  (flt_hi_i[i*DATA_W +: DATA_W]),
      .hit_o (ch_hit[i])
    );

    assign adc_chn_sel_o[i] = (state_q == ST_SAMPLE) && (ch_q == CH_W'(i));
  end

  assign adc_pd_o = (state_q == ST_IDLE) || (state_q == ST_SLEEP);
  assign np_hit   = (np_thresh_i != '0) && (np_cnt >= np_thresh_i);
  assign intr_o   = np_hit;
  assign wakeup_o = np_hit & promoted_q;

  // R2
  fsm_rst_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsm_rst_i |=> (state_q == ST_IDLE) && pwr_cnt == '0 && wk_cnt == '0
                  && lp_cnt == '0 && np_cnt == '0);

  // R3
  sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(adc_chn_sel_o) && !$isunknown(adc_chn_sel_o));

  // R4
  pwrup_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(adc_chn_sel_o[0]) && $past(state_q) == ST_PWRUP)
      |-> ({1'b0, $past(pwr_cnt)} + (PWR_W+1)'(1)) >= {1'b0, $past(pwrup_time_i)});

  // R5
  sleep_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SLEEP && en_i && !fsm_rst_i && lp_mode_i && !wk_done)
      |=> adc_pd_o && adc_chn_sel_o == '0);

  // R7
  sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|adc_chn_sel_o && !adc_valid_i && !sync_clr) |=> $stable(adc_chn_sel_o));

  // R12
  disable_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> adc_pd_o && adc_chn_sel_o == '0 && !intr_o);
endmodule

// File: tb/tb_adc_lp_sampler.sv
module tb_adc_lp_sampler;
  localparam int NUM_CH = 2;
  localparam int DW     = 10;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, en, fsm_rst, lp_mode, valid;
  logic [7:0]  pwrup_time, lp_th, np_th;
  logic [15:0] wake_time;
  logic [NUM_CH*DW-1:0] lo, hi;
  logic [DW-1:0] data;
  logic pd, intr, wake;
  logic [NUM_CH-1:0] sel;

  adc_lp_sampler dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .fsm_rst_i(fsm_rst),
    .lp_mode_i(lp_mode), .pwrup_time_i(pwrup_time), .wakeup_time_i(wake_time),
    .lp_thresh_i(lp_th), .np_thresh_i(np_th), .flt_lo_i(lo), .flt_hi_i(hi),
    .adc_data_i(data), .adc_valid_i(valid), .adc_pd_o(pd),
    .adc_chn_sel_o(sel), .intr_o(intr), .wakeup_o(wake));

  int checks = 0, fails = 0, cyc = 0, sel_bad = 0;
  always @(posedge clk) cyc++;
  always @(negedge clk) if (rst_n === 1'b1 && ($countones(sel) > 1 || $isunknown(sel))) sel_bad++;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic serve(input logic [DW-1:0] d0, input logic [DW-1:0] d1);
    logic [DW-1:0] d [NUM_CH];
    d[0] = d0; d[1] = d1;
    for (int c = 0; c < NUM_CH; c++) begin
      while (sel[c] !== 1'b1) @(negedge clk);
      data = d[c]; valid = 1'b1;
      @(negedge clk);
      valid = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic wait_fall(output int t);
    while (pd !== 1'b1) @(negedge clk);
    while (pd !== 1'b0) @(negedge clk);
    t = cyc;
  endtask

  typedef struct packed {
    logic [DW-1:0] d0;
    logic [DW-1:0] d1;
    logic          irq;
  } vec_t;

  // np_thresh 3, window ch0 [100,200], ch1 [300,400]
  localparam vec_t VEC [10] = '{
    '{10'd150, 10'd350, 1'b0},
    '{10'd100, 10'd400, 1'b0},
    '{10'd200, 10'd300, 1'b1},
    '{10'd150, 10'd350, 1'b1},
    '{10'd99,  10'd350, 1'b0},
    '{10'd150, 10'd350, 1'b0},
    '{10'd150, 10'd401, 1'b0},
    '{10'd150, 10'd350, 1'b0},
    '{10'd150, 10'd350, 1'b0},
    '{10'd150, 10'd350, 1'b1}
  };

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired (all requirements)");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int t0, t1, ta, tb, lows;
    rst_n = 1'b0; en = 1'b0; fsm_rst = 1'b0; lp_mode = 1'b0; valid = 1'b0; data = '0;
    pwrup_time = 8'd5; wake_time = 16'd40; lp_th = 8'd3; np_th = 8'd3;
    lo = {10'd300, 10'd100}; hi = {10'd400, 10'd200};
    repeat (3) @(negedge clk);
    chk("R1", "pd in reset", pd, 1); chk("R1", "sel in reset", sel, 0);
    chk("R1", "intr in reset", intr, 0); chk("R1", "wakeup in reset", wake, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R12", "pd while disabled", pd, 1); chk("R12", "sel while disabled", sel, 0);

    // R4 power-up settling count
    en = 1'b1;
    while (pd !== 1'b0) @(negedge clk);
    t0 = cyc;
    while (sel[0] !== 1'b1) @(negedge clk);
    t1 = cyc;
    chk("R4", "pwrup cycles", t1 - t0, 5);
    // R7 select held without data
    repeat (6) @(negedge clk);
    chk("R7", "sel0 held", sel, 2'b01);

    // R8 R11 vector walk in normal-power mode
    foreach (VEC[i]) begin
      serve(VEC[i].d0, VEC[i].d1);
      chk("R11", $sformatf("intr vec %0d", i), intr, VEC[i].irq);
      chk("R11", $sformatf("wakeup vec %0d", i), wake, 0);
    end

    // R2 software reset
    fsm_rst = 1'b1;
    @(negedge clk);
    chk("R2", "intr cleared", intr, 0); chk("R2", "pd idle", pd, 1); chk("R2", "sel idle", sel, 0);
    repeat (3) @(negedge clk);
    chk("R2", "pd held in reset", pd, 1);
    fsm_rst = 1'b0;
    while (pd !== 1'b0) @(negedge clk);
    t0 = cyc;
    while (sel[0] !== 1'b1) @(negedge clk);
    chk("R2", "full pwrup after reset", cyc - t0, 5);
    serve(10'd150, 10'd350);
    chk("R2", "count restarted", intr, 0);

    // R9 normal -> low power, R5 R6 R10 bursts
    lp_mode = 1'b1;
    serve(10'd150, 10'd350);
    chk("R9", "pd after lp burst", pd, 1);
    wait_fall(ta);
    serve(10'd150, 10'd50);
    lows = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (pd !== 1'b1) lows++;
    end
    chk("R5", "pd low cycles while asleep", lows, 0);
    wait_fall(tb);
    chk("R6", "burst interval", tb - ta, 40);
    serve(10'd150, 10'd350);
    serve(10'd150, 10'd350);
    chk("R10", "still low-power after miss cleared count", pd, 1);
    serve(10'd150, 10'd350);
    chk("R10", "promoted: stays powered", pd, 0);
    serve(10'd150, 10'd350);
    serve(10'd150, 10'd350);
    chk("R10", "np count restarted", intr, 0);
    serve(10'd150, 10'd350);
    chk("R11", "intr after promotion", intr, 1);
    chk("R11", "wakeup after promotion", wake, 1);

    // R9 low -> normal
    lp_mode = 1'b0;
    @(negedge clk);
    chk("R11", "wakeup drops with lp_mode", wake, 0);
    chk("R11", "intr stays", intr, 1);
    lp_mode = 1'b1;
    serve(10'd150, 10'd350);
    chk("R9", "sleep after re-entering lp", pd, 1);
    lp_mode = 1'b0;
    @(negedge clk);
    chk("R9", "wake from sleep on mode change", pd, 0);

    // R12 disable mid-run
    while (sel[0] !== 1'b1) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk("R12", "pd after disable", pd, 1); chk("R12", "sel after disable", sel, 0);
    chk("R12", "intr after disable", intr, 0);

    // R1 asynchronous reset
    en = 1'b1;
    while (sel[0] !== 1'b1) @(negedge clk);
    #2 rst_n = 1'b0;
    #1;
    chk("R1", "async pd", pd, 1); chk("R1", "async sel", sel, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk("R3", "select onehot/known violations", sel_bad, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule